// File: doc/BRIEF.md
# Fractional Phase-Stepping Clock Synthesizer

This block is the digital core of a phase-selecting frequency synthesizer. It runs on a base clock in which every cycle stands for one phase step of a multiphase oscillator: with eight equally spaced phases, one step is an eighth of an oscillator period. A programmable period word in 4.24 fixed point gives the average distance between synthesized edges, measured in phase steps. The block marks each synthesized edge with a one-cycle strobe and reports which of the eight phases that edge falls on. A phase multiplexer placed next to it can use that index to pick the matching oscillator phase.

A fixed-point accumulator carries the fractional remainder from one edge to the next. Individual periods alternate between the integer part and the integer part plus one, so the long-term average matches the programmed word exactly. From the edges the block forms a synthesized clock level. An integer post-divider (1 to 255) then produces a slower clock. The period word and the divisor are written through simple write strobes. A new value is held and takes effect only at an edge, so a running output never produces a runt pulse. Several copies can share one multiphase source, and each copy has its own period and divisor registers.

Top module: `fa_synth_core`

## Requirements
- R1: While reset is held, `edge_o`, `sclk_o` and `div_o` are 0. The first synthesized edge appears in the first cycle after the first clock edge with reset low, and it has phase index 0.
- R2: With a period word F (bits 27:24 integer, bits 23:0 fraction) and a remainder starting at 0, the gap between synthesized edge k and edge k+1 is floor((k+1)·F/2^24) − floor(k·F/2^24) base cycles. The total from the first edge to edge N is therefore floor((N−1)·F/2^24).
- R3: At every synthesized edge, `phase_o` equals the number of base cycles since the first edge after reset, modulo 8.
- R4: A period word whose integer field (bits 27:24) is below 2 is stored as 2.0 (0x2000000).
- R5: A period word written while running is first used for the period that starts at the next synthesized edge. The period already in progress keeps the old word.
- R6: `sclk_o` goes high at each synthesized edge and stays high for floor(L/2) base cycles, where L is the length of that period.
- R7: `div_o` rises only together with a synthesized edge, once every M synthesized periods, starting with the first edge.
- R8: For M ≥ 2, `div_o` stays high for the first floor(M/2) synthesized periods of each divided period. For M = 1, `div_o` equals `sclk_o`.
- R9: A divisor write of 0 is ignored. A valid divisor write takes effect at the next rising edge of `div_o`, so the divided period in progress completes with the old divisor.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Base clock, one cycle per phase step |
| rst_i | input | 1 | Synchronous reset, active high |
| freq_we_i | input | 1 | Period-word write strobe |
| freq_wdata_i | input | 28 | Period word, 4.24 fixed point in phase steps |
| div_we_i | input | 1 | Divisor write strobe |
| div_wdata_i | input | 8 | Post-divider value M |
| edge_o | output | 1 | One-cycle strobe on each synthesized edge |
| phase_o | output | 3 | Phase index of the current step |
| sclk_o | output | 1 | Synthesized clock level |
| div_o | output | 1 | Post-divided clock |

## Verification
The assertions check, on every cycle, the properties that are local in time. The first edge after reset sits on phase 0. Two edges are never adjacent. The phase index advances by one step per cycle. `sclk_o` is high on every edge. `div_o` rises only on an edge. Exact period lengths, the fractional long-term total, the duty of both clocks for each divisor, clamping of small period words, and the point at which a rewritten word or divisor takes hold all depend on a history of many edges. Only the bench scenarios show these, by comparing measured cycle counts against an arithmetic model.

// File: rtl/fa_synth_pkg.sv
package fa_synth_pkg;

   // Smallest integer period: keeps each half of the synthesized clock >= 1 step
   localparam int unsigned MIN_INT_STEPS = 2;

   typedef enum logic {
      FREQ_CLAMP  = 1'b0,   // low words are raised to the minimum period
      FREQ_REJECT = 1'b1    // low words are dropped, old value kept
   } freq_policy_e;

endpackage

// File: rtl/fa_freq_reg.sv
module fa_freq_reg
   import fa_synth_pkg::*;
#(
   parameter int unsigned  INT_W    = 4,
   parameter int unsigned  FRAC_W   = 24,
   parameter freq_policy_e POLICY   = FREQ_CLAMP,
   parameter logic [31:0]  RST_WORD = 32'h0400_0000,
   localparam int unsigned FW       = INT_W + FRAC_W
) (
   input  logic          clk_i,
   input  logic          rst_i,
   input  logic          we_i,
   input  logic [FW-1:0] wdata_i,
   input  logic          apply_i,
   output logic [FW-1:0] word_o
);

   localparam logic [FW-1:0] MIN_WORD = {INT_W'(MIN_INT_STEPS), {FRAC_W{1'b0}}};

   logic [FW-1:0] act_q;
   logic [FW-1:0] pend_q;
   logic          pend_v_q;
   logic          too_small;
   logic          accept;
   logic [FW-1:0] wr_word;

   assign too_small = (wdata_i[FW-1:FRAC_W] < INT_W'(MIN_INT_STEPS));

   if (POLICY == FREQ_CLAMP) begin : g_clamp
      assign accept  = we_i;
      assign wr_word = too_small ? MIN_WORD : wdata_i;
   end else begin : g_reject
      assign accept  = we_i && !too_small;
      assign wr_word = wdata_i;
   end

   // a pending word is used from the edge that follows its write
   assign word_o = pend_v_q ? pend_q : act_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         act_q    <= RST_WORD[FW-1:0];
         pend_q   <= '0;
         pend_v_q <= 1'b0;
      end else begin
         if (apply_i && pend_v_q) begin
            act_q <= pend_q;
         end
         if (accept) begin
            pend_q   <= wr_word;
            pend_v_q <= 1'b1;
         end else if (apply_i) begin
            pend_v_q <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/fa_phase_accum.sv
module fa_phase_accum #(
   parameter int unsigned  INT_W  = 4,
   parameter int unsigned  FRAC_W = 24,
   parameter int unsigned  PHASES = 8,
   localparam int unsigned FW     = INT_W + FRAC_W,
   localparam int unsigned LEN_W  = INT_W + 1,
   localparam int unsigned PH_W   = (PHASES > 1) ? $clog2(PHASES) : 1
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic [FW-1:0]    word_i,
   output logic             edge_o,
   output logic [LEN_W-1:0] len_o,
   output logic [PH_W-1:0]  phase_o
);

   localparam bit POW2 = (PHASES == (1 << PH_W));

   logic              live_q;
   logic [LEN_W-1:0]  cnt_q;
   logic [FRAC_W-1:0] resid_q;
   logic [PH_W-1:0]   pos_q;
   logic [PH_W-1:0]   pos_nxt;
   logic [FW:0]       sum;

   // period word plus carried fraction; integer part is this period's length
   assign sum     = {1'b0, word_i} + {{(INT_W + 1){1'b0}}, resid_q};
   assign len_o   = sum[FW:FRAC_W];
   assign edge_o  = live_q && (cnt_q == '0);
   assign phase_o = pos_q;

   if (POW2) begin : g_wrap_nat
      assign pos_nxt = pos_q + 1'b1;
   end else begin : g_wrap_cmp
      assign pos_nxt = (pos_q == PH_W'(PHASES - 1)) ? '0 : pos_q + 1'b1;
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         live_q  <= 1'b0;
         cnt_q   <= '0;
         resid_q <= '0;
         pos_q   <= '0;
      end else begin
         live_q <= 1'b1;
         if (live_q) begin
            pos_q <= pos_nxt;
            if (cnt_q == '0) begin
               cnt_q   <= len_o - LEN_W'(1);
               resid_q <= sum[FRAC_W-1:0];
            end else begin
               cnt_q <= cnt_q - LEN_W'(1);
            end
         end
      end
   end

endmodule

// File: rtl/fa_pulse_shaper.sv
module fa_pulse_shaper #(
   parameter int unsigned LEN_W = 5
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             edge_i,
   input  logic [LEN_W-1:0] len_i,
   output logic             sclk_o
);

   logic [LEN_W-1:0] hrem_q;

   // high for the edge cycle plus floor(L/2)-1 further cycles
   assign sclk_o = edge_i || (hrem_q != '0);

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         hrem_q <= '0;
      end else if (edge_i) begin
         hrem_q <= (len_i >> 1) - LEN_W'(1);
      end else if (hrem_q != '0) begin
         hrem_q <= hrem_q - LEN_W'(1);
      end
   end

endmodule

// File: rtl/fa_post_div.sv
module fa_post_div #(
   parameter int unsigned M_W   = 8,
   parameter int unsigned M_RST = 1
) (
   input  logic           clk_i,
   input  logic           rst_i,
   input  logic           edge_i,
   input  logic           sclk_i,
   input  logic           we_i,
   input  logic [M_W-1:0] wdata_i,
   output logic           div_o
);

   logic [M_W-1:0] m_act_q;
   logic [M_W-1:0] m_pend_q;
   logic           m_pv_q;
   logic [M_W-1:0] nxt_idx_q;
   logic [M_W-1:0] cur_idx_q;
   logic           run_q;
   logic           wrap;
   logic [M_W-1:0] m_now;
   logic [M_W-1:0] idx_now;
   logic           level;

   // a divided period starts when the next period index is zero
   assign wrap    = edge_i && (nxt_idx_q == '0);
   assign m_now   = (wrap && m_pv_q) ? m_pend_q : m_act_q;
   assign idx_now = edge_i ? nxt_idx_q : cur_idx_q;
   assign level   = (m_now == M_W'(1)) ? sclk_i : (idx_now < (m_now >> 1));
   assign div_o   = (edge_i || run_q) && level;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         m_act_q   <= M_W'(M_RST);
         m_pend_q  <= '0;
         m_pv_q    <= 1'b0;
         nxt_idx_q <= '0;
         cur_idx_q <= '0;
         run_q     <= 1'b0;
      end else begin
         if (edge_i) begin
            run_q     <= 1'b1;
            cur_idx_q <= nxt_idx_q;
            nxt_idx_q <= (nxt_idx_q == m_now - M_W'(1)) ? '0 : nxt_idx_q + 1'b1;
            if (wrap && m_pv_q) begin
               m_act_q <= m_pend_q;
            end
         end
         if (we_i && (wdata_i != '0)) begin
            m_pend_q <= wdata_i;
            m_pv_q   <= 1'b1;
         end else if (wrap) begin
            m_pv_q <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/fa_synth_core.sv
module fa_synth_core
   import fa_synth_pkg::*;
#(
   parameter int unsigned  PHASES   = 8,
   parameter int unsigned  INT_W    = 4,
   parameter int unsigned  FRAC_W   = 24,
   parameter int unsigned  M_W      = 8,
   parameter logic [31:0]  FREQ_RST = 32'h0400_0000,
   parameter int unsigned  M_RST    = 1,
   parameter freq_policy_e POLICY   = FREQ_CLAMP,
   localparam int unsigned FW       = INT_W + FRAC_W,
   localparam int unsigned LEN_W    = INT_W + 1,
   localparam int unsigned PH_W     = (PHASES > 1) ? $clog2(PHASES) : 1
) (
   input  logic            clk_i,
   input  logic            rst_i,
   input  logic            freq_we_i,
   input  logic [FW-1:0]   freq_wdata_i,
   input  logic            div_we_i,
   input  logic [M_W-1:0]  div_wdata_i,
   output logic            edge_o,
   output logic [PH_W-1:0] phase_o,
   output logic            sclk_o,
   output logic            div_o
);

   // elaboration-time parameter checks
   if (PHASES < 2) begin : g_chk_phases
      $error("fa_synth_core: PHASES must be at least 2");
   end
   if (INT_W < 2 || FRAC_W < 1) begin : g_chk_word
      $error("fa_synth_core: period word needs INT_W >= 2 and FRAC_W >= 1");
   end
   if (M_RST < 1 || M_RST >= (1 << M_W)) begin : g_chk_mrst
      $error("fa_synth_core: M_RST out of range");
   end
   if (FREQ_RST[FW-1:FRAC_W] < MIN_INT_STEPS) begin : g_chk_frst
      $error("fa_synth_core: FREQ_RST below minimum period");
   end

   logic [FW-1:0]    word;
   logic [LEN_W-1:0] len;
   logic             edge_w;
   logic             sclk_w;

   fa_freq_reg #(
      .INT_W   (INT_W),
      .FRAC_W  (FRAC_W),
      .POLICY  (POLICY),
      .RST_WORD(FREQ_RST)
   ) u_freq (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .we_i   (freq_we_i),
      .wdata_i(freq_wdata_i),
      .apply_i(edge_w),
      .word_o (word)
   );

   fa_phase_accum #(
      .INT_W (INT_W),
      .FRAC_W(FRAC_W),
      .PHASES(PHASES)
   ) u_accum (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .word_i (word),
      .edge_o (edge_w),
      .len_o  (len),
      .phase_o(phase_o)
   );

   fa_pulse_shaper #(
      .LEN_W(LEN_W)
   ) u_shape (
      .clk_i (clk_i),
      .rst_i (rst_i),
      .edge_i(edge_w),
      .len_i (len),
      .sclk_o(sclk_w)
   );

   fa_post_div #(
      .M_W  (M_W),
      .M_RST(M_RST)
   ) u_div (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .edge_i (edge_w),
      .sclk_i (sclk_w),
      .we_i   (div_we_i),
      .wdata_i(div_wdata_i),
      .div_o  (div_o)
   );

   assign edge_o = edge_w;
   assign sclk_o = sclk_w;

endmodule

// File: rtl/fa_synth_chk.sv
module fa_synth_chk #(
   parameter int unsigned PHASES = 8,
   parameter int unsigned PH_W   = 3
) (
   input logic            clk_i,
   input logic            rst_i,
   input logic            edge_o,
   input logic [PH_W-1:0] phase_o,
   input logic            sclk_o,
   input logic            div_o
);

   logic            s1_q;
   logic            s2_q;
   logic [PH_W-1:0] prev_ph_q;
   logic [PH_W-1:0] exp_ph;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         s1_q <= 1'b0;
         s2_q <= 1'b0;
      end else begin
         s1_q <= 1'b1;
         s2_q <= s1_q;
      end
      prev_ph_q <= phase_o;
   end

   assign exp_ph = (prev_ph_q == PH_W'(PHASES - 1)) ? '0 : prev_ph_q + 1'b1;

   // R1: first live cycle carries an edge on phase 0
   a_r1_first_edge: assert property (@(posedge clk_i) disable iff (rst_i)
      (s1_q && !s2_q) |-> (edge_o && phase_o == '0));

   // R2: periods are at least two steps, so edges never touch
   a_r2_min_gap: assert property (@(posedge clk_i) disable iff (rst_i)
      edge_o |=> !edge_o);

   // R3: phase index walks one step per base cycle
   a_r3_phase_step: assert property (@(posedge clk_i) disable iff (rst_i)
      s2_q |-> (phase_o == exp_ph));

   // R6: synthesized clock is high on every edge
   a_r6_sclk_on_edge: assert property (@(posedge clk_i) disable iff (rst_i)
      edge_o |-> sclk_o);

   // R7: divided clock only rises on an edge
   a_r7_div_rise_on_edge: assert property (@(posedge clk_i) disable iff (rst_i)
      $rose(div_o) |-> edge_o);

endmodule

bind fa_synth_core fa_synth_chk #(
   .PHASES(PHASES),
   .PH_W  (PH_W)
) u_chk (
   .clk_i  (clk_i),
   .rst_i  (rst_i),
   .edge_o (edge_o),
   .phase_o(phase_o),
   .sclk_o (sclk_o),
   .div_o  (div_o)
);

// File: tb/sim_fa_synth_core.sv
`timescale 1ns/1ps
module sim_fa_synth_core;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        freq_we = 1'b0;
   logic [27:0] freq_wdata = '0;
   logic        div_we = 1'b0;
   logic [7:0]  div_wdata = '0;
   logic        edge_o;
   logic [2:0]  phase_o;
   logic        sclk_o;
   logic        div_o;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2 clk = ~clk;

   fa_synth_core u0 (
      .clk_i       (clk),
      .rst_i       (rst),
      .freq_we_i   (freq_we),
      .freq_wdata_i(freq_wdata),
      .div_we_i    (div_we),
      .div_wdata_i (div_wdata),
      .edge_o      (edge_o),
      .phase_o     (phase_o),
      .sclk_o      (sclk_o),
      .div_o       (div_o)
   );

   // {written word, effective word, M}
   localparam logic [63:0] CASES [6] = '{
      {28'h4000000, 28'h4000000, 8'd1},
      {28'h2800000, 28'h2800000, 8'd2},
      {28'h3555555, 28'h3555555, 8'd3},
      {28'h1800000, 28'h2000000, 8'd4},
      {28'hFFFFFFF, 28'hFFFFFFF, 8'd5},
      {28'h0000000, 28'h2000000, 8'd255}
   };
   localparam int NEDGES = 600;

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // reset, then write word and divisor; returns sampling the first edge cycle
   task automatic start_run(input logic [27:0] fw, input logic [7:0] m);
      @(negedge clk); rst = 1'b1; freq_we = 1'b0; div_we = 1'b0;
      @(negedge clk);
      chk(!edge_o && !sclk_o && !div_o, "R1 outputs low in reset",
          {edge_o, sclk_o, div_o}, 0);
      @(negedge clk);
      rst = 1'b0; freq_we = 1'b1; freq_wdata = fw; div_we = 1'b1; div_wdata = m;
      @(negedge clk);
      freq_we = 1'b0; div_we = 1'b0;
      chk(edge_o && phase_o == 3'd0, "R1 first edge on phase 0",
          {edge_o, phase_o}, 8);
   endtask

   task automatic gap_to_edge(output int n);
      n = 0;
      do begin
         @(negedge clk); freq_we = 1'b0; div_we = 1'b0; n++;
      end while (!edge_o && n < 100);
   endtask

   task automatic gap_to_div_rise(output int n);
      logic prev;
      prev = div_o; n = 0;
      forever begin
         @(negedge clk); freq_we = 1'b0; div_we = 1'b0; n++;
         if ((div_o && !prev) || n >= 200) break;
         prev = div_o;
      end
   endtask

   task automatic run_case(input int ci);
      logic [27:0] fw, fe;
      logic [7:0]  mm;
      int cyc, last, ecount, shi, exp_len, idx, rises;
      int err_len, err_ph, err_sclk, err_div;
      longint total, resid, s, exp_total;
      logic prev_div, exp_div;
      {fw, fe, mm} = CASES[ci];
      start_run(fw, mm);
      cyc = 0; last = 0; ecount = 0; shi = 0; exp_len = 0; idx = 0; rises = 0;
      err_len = 0; err_ph = 0; err_sclk = 0; err_div = 0;
      total = 0; resid = 0; prev_div = 1'b0;
      forever begin
         if (edge_o) begin
            if (ecount > 0) begin
               if (cyc - last != exp_len) err_len++;
               if (shi != exp_len / 2) err_sclk++;
               total += cyc - last;
            end
            if (phase_o != 3'(cyc % 8)) err_ph++;
            s = longint'(fe) + resid;
            exp_len = int'(s >> 24);
            resid = s & 64'hFF_FFFF;
            last = cyc; shi = 0; ecount++;
            idx = (ecount - 1) % int'(mm);
         end
         if (sclk_o) shi++;
         exp_div = (mm == 8'd1) ? sclk_o : (idx < int'(mm) / 2);
         if (div_o != exp_div) err_div++;
         if (div_o && !prev_div) rises++;
         prev_div = div_o;
         if (ecount == NEDGES && edge_o) break;
         @(negedge clk); cyc++;
      end
      exp_total = (longint'(NEDGES - 1) * longint'(fe)) >> 24;
      chk(err_len == 0, $sformatf("R2 per-period length case %0d", ci), err_len, 0);
      chk(total == exp_total, $sformatf("R2 total steps case %0d", ci), total, exp_total);
      chk(err_ph == 0, $sformatf("R3 edge phase case %0d", ci), err_ph, 0);
      chk(err_sclk == 0, $sformatf("R6 sclk high time case %0d", ci), err_sclk, 0);
      chk(rises == (NEDGES - 1) / int'(mm) + 1, $sformatf("R7 div rises case %0d", ci),
          rises, (NEDGES - 1) / int'(mm) + 1);
      chk(err_div == 0, $sformatf("R8 div waveform case %0d", ci), err_div, 0);
      if (fw != fe) begin
         // R4: small word behaves as 2.0, so every period is 2 steps
         chk(err_len == 0 && total == longint'(2 * (NEDGES - 1)),
             $sformatf("R4 clamp case %0d", ci), total, 2 * (NEDGES - 1));
      end
   endtask

   initial begin
      int g;
      for (int ci = 0; ci < 6; ci++) run_case(ci);

      // R5: word rewritten in the edge cycle; current period keeps 2.0
      start_run(28'h2000000, 8'd1);
      freq_we = 1'b1; freq_wdata = 28'h3000000;
      gap_to_edge(g); chk(g == 2, "R5 period in progress keeps old word", g, 2);
      gap_to_edge(g); chk(g == 3, "R5 new word after next edge", g, 3);
      gap_to_edge(g); chk(g == 3, "R5 new word persists", g, 3);

      // R9: divisor 0 ignored, change waits for the next div_o rise
      start_run(28'h2000000, 8'd4);
      div_we = 1'b1; div_wdata = 8'd0;
      gap_to_div_rise(g); chk(g == 8, "R9 zero divisor ignored", g, 8);
      div_we = 1'b1; div_wdata = 8'd2;
      gap_to_div_rise(g); chk(g == 8, "R9 current divided period completes", g, 8);
      gap_to_div_rise(g); chk(g == 4, "R9 new divisor after rise", g, 4);

      if (!done) begin
         done = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++; errors++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule